// File: doc/BRIEF.md
# Quad Low-Side Gate Supervisor

This block stands between four channel command bits and the gate-enable lines of four low-side switches, and adds fault supervision to them. Each enabled channel drives its gate exactly as its command asks. A per-channel overcurrent indication is filtered by a deglitch counter. When the indication is held long enough, that channel alone is locked off for a fixed retry period, after which it follows its command again without help.

Three chip-wide conditions act on top of the per-channel logic. A high-active clear input holds every gate off for as long as it is asserted and ends any lockout at once. An over-temperature flag holds every gate off while it is present. A low-supply flag holds every gate off and wipes all deglitch and retry counting. The low-active fault output reports any active lockout and over-temperature. Every input passes through a two-flop synchronizer, and all durations are counted in cycles of the one system clock. Leaving the power-on reset behaves like a clear pulse.

Top module: `quad_lsd_guard`

## Requirements
- R1: With the enable input low and no shutdown condition, gate_on[n] equals chan_cmd[n] (1 = switch conducting). A command change appears on gate_on at the second rising edge after it is applied.
- R2: While drv_en_n is high, all gate_on bits are 0, whatever the commands are.
- R3: A channel is locked off only after its synchronized oc_flag bit has been high on DEG_CYC consecutive clock edges. Any low sample restarts that channel's count from zero.
- R4: A locked channel stays off for exactly RETRY_CYC clock edges, then follows its command again. fault_n is 0 for the whole lockout and returns to 1 in the first cycle after the last lockout ends.
- R5: A lockout turns off only the channel that tripped. Every other channel keeps following its command.
- R6: While clear_req is high, all gate_on bits are 0 and any lockout is ended. After clear_req falls, the channels follow their commands again.
- R7: While over_temp is high, all gate_on bits are 0 and fault_n is 0. Normal operation resumes once the flag falls.
- R8: While low_supply is high, all gate_on bits are 0 and all lockouts and deglitch counts are cleared. The flag does not drive fault_n by itself.
- R9: During and just after sys_rst_n low, gate_on is 0000 and fault_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Power-on reset, active low, asynchronous |
| chan_cmd | input | NUM_CH | Per-channel on command, 1 = conduct |
| drv_en_n | input | 1 | Output enable, active low |
| clear_req | input | 1 | Supervisor clear, active high |
| oc_flag | input | NUM_CH | Per-channel overcurrent indication |
| over_temp | input | 1 | Die over-temperature indication |
| low_supply | input | 1 | Supply undervoltage indication |
| gate_on | output | NUM_CH | Per-channel gate enable, 1 = switch on |
| fault_n | output | 1 | Fault indication, active low |

## Verification
The assertions are written against the synchronized copies of the inputs. They assume that every asynchronous flag stays at a level for at least one full clock cycle, so that each level reaches the second synchronizer stage. The stimulus changes inputs only on falling clock edges and holds each level for whole cycles. The deglitch and retry windows are checked at both sides of their boundary. Short overcurrent pulses with single-cycle gaps are used to show that the count restarts.

// File: rtl/qlg_pkg.sv
package qlg_pkg;

    typedef enum logic {
        CH_ARMED  = 1'b0,
        CH_LOCKED = 1'b1
    } ch_mode_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/qlg_sync.sv
module qlg_sync #(
    parameter int unsigned WIDTH   = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
        end else begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/qlg_channel.sv
module qlg_channel
    import qlg_pkg::*;
#(
    parameter int unsigned DEG_CYC   = 350,
    parameter int unsigned RETRY_CYC = 120000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_s,
    input  logic kill,
    output logic locked
);
    localparam int unsigned MAX_CNT = max_u(DEG_CYC, RETRY_CYC);
    localparam int unsigned CW      = $clog2(MAX_CNT + 1);
    localparam logic [CW-1:0] DEG_LAST   = CW'(DEG_CYC - 1);
    localparam logic [CW-1:0] RETRY_LAST = CW'(RETRY_CYC - 1);

    typedef struct packed {
        ch_mode_e      mode;
        logic [CW-1:0] cnt;
    } ch_state_t;

    ch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (kill) begin
            st_d.mode = CH_ARMED;
            st_d.cnt  = '0;
        end else begin
            unique case (st_q.mode)
                CH_ARMED: begin
                    if (!oc_s) begin
                        st_d.cnt = '0;
                    end else if (st_q.cnt == DEG_LAST) begin
                        st_d.mode = CH_LOCKED;
                        st_d.cnt  = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                CH_LOCKED: begin
                    if (st_q.cnt == RETRY_LAST) begin
                        st_d.mode = CH_ARMED;
                        st_d.cnt  = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: st_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked = (st_q.mode == CH_LOCKED);

    // R3
    trip_needs_oc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(oc_s));

    // R4
    lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !kill && st_q.cnt != RETRY_LAST) |=> locked);

    // R6
    kill_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !locked);
endmodule

// File: rtl/quad_lsd_guard.sv
module quad_lsd_guard #(
    parameter int unsigned NUM_CH     = 4,
    parameter int unsigned DEG_CYC    = 350,
    parameter int unsigned RETRY_CYC  = 120000,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              sys_rst_n,
    input  logic [NUM_CH-1:0] chan_cmd,
    input  logic              drv_en_n,
    input  logic              clear_req,
    input  logic [NUM_CH-1:0] oc_flag,
    input  logic              over_temp,
    input  logic              low_supply,
    output logic [NUM_CH-1:0] gate_on,
    output logic              fault_n
);
    localparam int unsigned SW = 2 * NUM_CH + 4;
    // clear resets high so leaving power-on reset acts like a clear pulse
    localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b0, 1'b1, 1'b1, {(2*NUM_CH){1'b0}}};

    logic [SW-1:0]     raw_in, syn;
    logic [NUM_CH-1:0] cmd_s, oc_s, lock_v;
    logic              en_n_s, clr_s, hot_s, uv_s, kill, global_off;

    assign raw_in = {low_supply, over_temp, clear_req, drv_en_n, oc_flag, chan_cmd};

    qlg_sync #(.WIDTH(SW), .STAGES(SYNC_DEPTH), .RST_VAL(SYNC_RST)) in_sync_i (
        .clk     (clk),
        .rst_n   (sys_rst_n),
        .async_i (raw_in),
        .sync_o  (syn)
    );

    assign cmd_s  = syn[NUM_CH-1:0];
    assign oc_s   = syn[2*NUM_CH-1:NUM_CH];
    assign en_n_s = syn[2*NUM_CH];
    assign clr_s  = syn[2*NUM_CH+1];
    assign hot_s  = syn[2*NUM_CH+2];
    assign uv_s   = syn[2*NUM_CH+3];

    assign kill       = clr_s | uv_s;
    assign global_off = en_n_s | kill | hot_s;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        qlg_channel #(.DEG_CYC(DEG_CYC), .RETRY_CYC(RETRY_CYC)) ch_i (
            .clk    (clk),
            .rst_n  (sys_rst_n),
            .oc_s   (oc_s[g]),
            .kill   (kill),
            .locked (lock_v[g])
        );

        assign gate_on[g] = cmd_s[g] & ~lock_v[g] & ~global_off;

        // R5
        locked_off_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
            lock_v[g] |-> !gate_on[g]);
    end

    assign fault_n = ~((|lock_v) | hot_s);

    // R2
    enable_gate_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        en_n_s |-> (gate_on == '0));

    // R7
    hot_fault_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        hot_s |-> (!fault_n && gate_on == '0));

    // R8
    uv_clears_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        uv_s |=> (lock_v == '0));
endmodule

// File: tb/quad_lsd_guard_tb.sv
`timescale 1ns/1ps
module quad_lsd_guard_tb_top;
    localparam int unsigned NCH   = 4;
    localparam int unsigned DEG   = 8;
    localparam int unsigned RETRY = 40;

    logic clk = 1'b0;
    logic sys_rst_n = 1'b0;
    logic [NCH-1:0] chan_cmd = '0, oc_flag = '0;
    logic drv_en_n = 1'b0, clear_req = 1'b0, over_temp = 1'b0, low_supply = 1'b0;
    logic [NCH-1:0] gate_on;
    logic fault_n;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    quad_lsd_guard #(.NUM_CH(NCH), .DEG_CYC(DEG), .RETRY_CYC(RETRY)) dut_i (
        .clk(clk), .sys_rst_n(sys_rst_n), .chan_cmd(chan_cmd), .drv_en_n(drv_en_n),
        .clear_req(clear_req), .oc_flag(oc_flag), .over_temp(over_temp),
        .low_supply(low_supply), .gate_on(gate_on), .fault_n(fault_n)
    );

    // {cmd[3:0], en_n, hot, exp_gate[3:0], exp_fault_n}
    localparam logic [10:0] VEC [7] = '{
        {4'b0001, 1'b0, 1'b0, 4'b0001, 1'b1},   // R1
        {4'b1010, 1'b0, 1'b0, 4'b1010, 1'b1},   // R1
        {4'b1111, 1'b0, 1'b0, 4'b1111, 1'b1},   // R1
        {4'b1111, 1'b1, 1'b0, 4'b0000, 1'b1},   // R2
        {4'b0110, 1'b1, 1'b0, 4'b0000, 1'b1},   // R2
        {4'b0110, 1'b0, 1'b1, 4'b0000, 1'b0},   // R7
        {4'b0110, 1'b0, 1'b0, 4'b0110, 1'b1}    // R7
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [NCH-1:0] eg, input logic ef);
        n_chk++;
        if (gate_on !== eg || fault_n !== ef) begin
            n_bad++;
            $display("FAIL %s: gate_on=%b fault_n=%b expected gate_on=%b fault_n=%b",
                     tag, gate_on, fault_n, eg, ef);
        end
    endtask

    task automatic trip_ch0();
        oc_flag[0] = 1'b1;
        tick(DEG + 2);
        oc_flag[0] = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(3);
        chk("R9 in reset", 4'b0000, 1'b1);
        sys_rst_n = 1'b1;
        tick(1);
        chk("R9 after reset", 4'b0000, 1'b1);
        tick(3);

        for (int i = 0; i < 7; i++) begin
            chan_cmd  = VEC[i][10:7];
            drv_en_n  = VEC[i][6];
            over_temp = VEC[i][5];
            tick(1);
            if (i == 0) chk("R1 latency before second edge", 4'b0000, 1'b1);
            tick(1);
            chk($sformatf("R1 R2 R7 vector %0d", i), VEC[i][4:1], VEC[i][0]);
            tick(2);
        end

        // R3 / R4 / R5 deglitch and retry boundaries
        chan_cmd = 4'b0011;
        tick(3);
        oc_flag[0] = 1'b1;
        tick(DEG + 1);
        chk("R3 still on before deglitch ends", 4'b0011, 1'b1);
        tick(1);
        chk("R3 R5 channel 0 tripped alone", 4'b0010, 1'b0);
        oc_flag[0] = 1'b0;
        tick(RETRY - 1);
        chk("R4 lockout last cycle", 4'b0010, 1'b0);
        tick(1);
        chk("R4 released after retry", 4'b0011, 1'b1);

        // R3 short pulses restart the count
        oc_flag[0] = 1'b1; tick(DEG - 1);
        oc_flag[0] = 1'b0; tick(1);
        oc_flag[0] = 1'b1; tick(DEG - 1);
        oc_flag[0] = 1'b0; tick(4);
        chk("R3 glitches do not trip", 4'b0011, 1'b1);

        // R6 clear aborts lockout
        chan_cmd = 4'b0001;
        trip_ch0();
        chk("R6 setup lockout", 4'b0000, 1'b0);
        clear_req = 1'b1;
        tick(3);
        chk("R6 clear holds off and ends lockout", 4'b0000, 1'b1);
        tick(5);
        clear_req = 1'b0;
        tick(2);
        chk("R6 follows command after clear", 4'b0001, 1'b1);

        // R8 low supply wipes lockout
        chan_cmd = 4'b0011;
        tick(2);
        trip_ch0();
        chk("R8 setup lockout", 4'b0010, 1'b0);
        low_supply = 1'b1;
        tick(3);
        chk("R8 all off, lockout cleared", 4'b0000, 1'b1);
        low_supply = 1'b0;
        tick(2);
        chk("R8 resumes after flag", 4'b0011, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule